// File: doc/BRIEF.md
# Burst assembly queue controller

This block sits at the ingress edge of an optical burst switching node. Packets reach it already line-decoded and stripped of their Ethernet framing. Each one is presented as a descriptor carrying a destination, a QoS class and a 16-bit byte length. The block sorts every descriptor into an assembly queue keyed by the destination and class pair. For each queue it keeps a running burst length and an assembly timer.

A queue asks for release as soon as either of two conditions holds. The first is that its accumulated length has gone past a shared, runtime-programmable threshold. The second is that its timer has reached a shared, runtime-programmable timeout. When several queues are ready at once, a round-robin arbiter chooses one. The chosen burst is then offered on a req/ack handshake that carries the queue index, the final burst length and the cause of the release.

The descriptor input is valid/ready. A descriptor is taken on a cycle where `pkt_valid` and `pkt_ready` are both high. `pkt_ready` drops only for descriptors aimed at the queue whose burst is currently on offer, and only while `burst_ack` is low. Traffic to every other queue flows freely. The burst output holds all its fields stable from the rise of `burst_req` until the cycle in which `burst_ack` is seen high.

Top module: `burst_assembler`

## Requirements
- R1: A descriptor goes to queue index `dest*2 + qos`, which is `{dest, qos}` with 4 destinations and 2 classes. `burst_queue` reports that index for the queue's burst.
- R2: `burst_len` equals the sum of `pkt_len` over all descriptors accepted into that queue since the queue was last cleared.
- R3: When an accepted descriptor makes the queue length strictly greater than `cfg_len_thresh`, `burst_req` rises one clock after the accepting edge with `burst_cause` = 0. A length equal to the threshold raises nothing.
- R4: The timer of an empty queue holds at zero. It starts counting at the first descriptor accepted into that empty queue. If the length trigger does not fire first, `burst_req` rises `cfg_timeout + 1` clocks after that accepting edge with `burst_cause` = 1. An empty queue never requests.
- R5: When the length and timeout conditions both hold for a queue, exactly one burst is offered, and its `burst_cause` is 0 (length wins).
- R6: While `burst_req` is high and `burst_ack` is low, `burst_queue`, `burst_len` and `burst_cause` stay unchanged and `burst_req` stays high.
- R7: On the edge where `burst_req` and `burst_ack` are both high, the offered queue's length and timer clear. A descriptor accepted into the same queue on that edge becomes the first packet of the next burst.
- R8: `pkt_ready` is low only when the descriptor targets the queue on offer and `burst_ack` is low. In the ack cycle it is high.
- R9: Among queues ready at the same time, the grant goes to the first ready index at or after the one following the last granted index, in cyclic order. After reset the search starts at 0. A new grant may follow an ack on the very next cycle.
- R10: The burst length saturates at 2^20-1 rather than wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pkt_valid | input | 1 | Descriptor valid |
| pkt_ready | output | 1 | Descriptor ready |
| pkt_dest | input | 2 | Destination of the packet |
| pkt_qos | input | 1 | QoS class of the packet |
| pkt_len | input | 16 | Packet length in bytes |
| cfg_len_thresh | input | 20 | Length threshold (release when exceeded) |
| cfg_timeout | input | 16 | Assembly timeout in clocks |
| burst_req | output | 1 | Burst release request |
| burst_ack | input | 1 | Burst release accepted |
| burst_queue | output | 3 | Queue index of the offered burst |
| burst_len | output | 20 | Byte length of the offered burst |
| burst_cause | output | 1 | 0 = length threshold, 1 = timeout |

## Verification
Each kind of internal fault shows up at the ports within a bounded number of cycles:
- A length counter that misses a clear or an add appears at the next offer of that queue as a wrong `burst_len`, or as a request one packet early or late.
- A timer that starts on the wrong edge moves the rise of `burst_req` away from exactly `cfg_timeout + 1` clocks after the first packet.
- A broken round-robin pointer shows as a wrong `burst_queue` on the first grant when three or more queues are ready together.
- A missing stall shows as a change in `burst_len` during an offer.

// File: rtl/burst_asm_pkg.sv
`timescale 1ns/1ps
package burst_asm_pkg;
  typedef enum logic {
    CAUSE_LENGTH  = 1'b0,
    CAUSE_TIMEOUT = 1'b1
  } burst_cause_e;
endpackage

// File: rtl/burst_pkt_classifier.sv
`timescale 1ns/1ps
module burst_pkt_classifier #(
  parameter int N_DEST = 4,
  parameter int N_QOS  = 2,
  parameter int DEST_W = 2,
  parameter int QOS_W  = 1,
  parameter int NQ     = 8,
  parameter int QW     = 3
) (
  input  logic [DEST_W-1:0] dest,
  input  logic [QOS_W-1:0]  qos,
  output logic [QW-1:0]     q_idx,
  output logic [NQ-1:0]     q_hot
);
  // R1: queue key is destination-major, class-minor
  always_comb begin
    q_idx = QW'(dest) * QW'(N_QOS) + QW'(qos);
    q_hot = '0;
    for (int i = 0; i < NQ; i++) begin
      if (q_idx == QW'(i)) q_hot[i] = 1'b1;
    end
  end
endmodule

// File: rtl/burst_queue_tracker.sv
`timescale 1ns/1ps
module burst_queue_tracker #(
  parameter int PKT_LEN_W   = 16,
  parameter int BURST_LEN_W = 20,
  parameter int TMR_W       = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   add,
  input  logic [PKT_LEN_W-1:0]   add_len,
  input  logic                   clear,
  input  logic [BURST_LEN_W-1:0] thresh,
  input  logic [TMR_W-1:0]       timeout,
  output logic [BURST_LEN_W-1:0] len,
  output logic                   active,
  output logic                   len_hit,
  output logic                   tmo_hit
);
  logic [TMR_W-1:0]       timer;
  logic [BURST_LEN_W:0]   sum;
  logic [BURST_LEN_W-1:0] len_next;
  logic [TMR_W-1:0]       timer_inc;

  always_comb begin
    sum       = {1'b0, len} + (BURST_LEN_W+1)'(add_len);
    len_next  = sum[BURST_LEN_W] ? '1 : sum[BURST_LEN_W-1:0]; // R10 saturate
    timer_inc = (timer == '1) ? timer : timer + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      len    <= '0;
      timer  <= '0;
      active <= 1'b0;
    end else if (clear) begin
      // R7: new burst may start in the clear cycle
      active <= add;
      len    <= add ? BURST_LEN_W'(add_len) : '0;
      timer  <= '0;
    end else if (add) begin
      active <= 1'b1;
      len    <= len_next;
      timer  <= active ? timer_inc : '0;
    end else if (active) begin
      timer  <= timer_inc;
    end
  end

  assign len_hit = active && (len > thresh);
  assign tmo_hit = active && (timer >= timeout);

  AST_IDLE_TIMER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> (timer == '0)); // R4
  AST_IDLE_LEN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> (len == '0)); // R2
  AST_LEN_NO_SHRINK: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !clear) |=> (len >= $past(len))); // R10
  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (clear && !add) |=> (!active && len == '0)); // R7
endmodule

// File: rtl/burst_rr_arbiter.sv
`timescale 1ns/1ps
module burst_rr_arbiter #(
  parameter int N = 8,
  parameter int W = 3
) (
  input  logic [N-1:0] req,
  input  logic [W-1:0] ptr,
  output logic         gnt_valid,
  output logic [W-1:0] gnt_idx
);
  always_comb begin
    gnt_valid = 1'b0;
    gnt_idx   = '0;
    for (int k = 0; k < N; k++) begin
      int j;
      j = (int'(ptr) + k) % N;
      if (!gnt_valid && req[j]) begin
        gnt_valid = 1'b1;
        gnt_idx   = W'(j);
      end
    end
  end

  always_comb begin
    if (gnt_valid) begin
      AST_GNT_REQUESTED: assert (req[gnt_idx]); // R9
    end
  end
endmodule

// File: rtl/burst_assembler.sv
`timescale 1ns/1ps
module burst_assembler #(
  parameter int N_DEST      = 4,
  parameter int N_QOS       = 2,
  parameter int PKT_LEN_W   = 16,
  parameter int BURST_LEN_W = 20,
  parameter int TMR_W       = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        pkt_valid,
  output logic                        pkt_ready,
  input  logic [$clog2(N_DEST)-1:0]   pkt_dest,
  input  logic [$clog2(N_QOS)-1:0]    pkt_qos,
  input  logic [PKT_LEN_W-1:0]        pkt_len,
  input  logic [BURST_LEN_W-1:0]      cfg_len_thresh,
  input  logic [TMR_W-1:0]            cfg_timeout,
  output logic                        burst_req,
  input  logic                        burst_ack,
  output logic [$clog2(N_DEST*N_QOS)-1:0] burst_queue,
  output logic [BURST_LEN_W-1:0]      burst_len,
  output logic                        burst_cause
);
  import burst_asm_pkg::*;

  localparam int DEST_W = $clog2(N_DEST);
  localparam int QOS_W  = $clog2(N_QOS);
  localparam int NQ     = N_DEST * N_QOS;
  localparam int QW     = $clog2(NQ);

  logic [QW-1:0]          in_q;
  logic [NQ-1:0]          in_hot;
  logic                   offer_valid;
  logic [QW-1:0]          offer_q;
  burst_cause_e           offer_cause;
  logic [QW-1:0]          rr_ptr;
  logic                   stall;
  logic                   accept;
  logic                   ack_fire;
  logic [NQ-1:0]          add_vec;
  logic [NQ-1:0]          clr_vec;
  logic [NQ-1:0]          active_vec;
  logic [NQ-1:0]          len_hit_vec;
  logic [NQ-1:0]          tmo_hit_vec;
  logic [NQ-1:0]          arb_req;
  logic [BURST_LEN_W-1:0] len_arr [NQ];
  logic                   gnt_valid;
  logic [QW-1:0]          gnt_idx;

  burst_pkt_classifier #(
    .N_DEST(N_DEST), .N_QOS(N_QOS), .DEST_W(DEST_W),
    .QOS_W(QOS_W), .NQ(NQ), .QW(QW)
  ) u_classify (
    .dest (pkt_dest),
    .qos  (pkt_qos),
    .q_idx(in_q),
    .q_hot(in_hot)
  );

  // R8: back-pressure only toward the queue whose burst is on offer
  assign stall     = offer_valid && !burst_ack && (in_q == offer_q);
  assign pkt_ready = !stall;
  assign accept    = pkt_valid && pkt_ready;
  assign ack_fire  = offer_valid && burst_ack;

  for (genvar g = 0; g < NQ; g++) begin : g_queue
    assign add_vec[g] = accept && in_hot[g];
    assign clr_vec[g] = ack_fire && (offer_q == QW'(g));
    // R5: one request per queue regardless of how many triggers hold
    assign arb_req[g] = (len_hit_vec[g] || tmo_hit_vec[g]) && !clr_vec[g];

    burst_queue_tracker #(
      .PKT_LEN_W(PKT_LEN_W), .BURST_LEN_W(BURST_LEN_W), .TMR_W(TMR_W)
    ) u_track (
      .clk    (clk),
      .rst_n  (rst_n),
      .add    (add_vec[g]),
      .add_len(pkt_len),
      .clear  (clr_vec[g]),
      .thresh (cfg_len_thresh),
      .timeout(cfg_timeout),
      .len    (len_arr[g]),
      .active (active_vec[g]),
      .len_hit(len_hit_vec[g]),
      .tmo_hit(tmo_hit_vec[g])
    );
  end

  burst_rr_arbiter #(.N(NQ), .W(QW)) u_arb (
    .req      (arb_req),
    .ptr      (rr_ptr),
    .gnt_valid(gnt_valid),
    .gnt_idx  (gnt_idx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      offer_valid <= 1'b0;
      offer_q     <= '0;
      offer_cause <= CAUSE_LENGTH;
      rr_ptr      <= '0;
    end else if (!offer_valid || ack_fire) begin
      offer_valid <= gnt_valid;
      if (gnt_valid) begin
        offer_q     <= gnt_idx;
        offer_cause <= len_hit_vec[gnt_idx] ? CAUSE_LENGTH : CAUSE_TIMEOUT; // R5
        rr_ptr      <= (gnt_idx == QW'(NQ-1)) ? '0 : gnt_idx + 1'b1;      // R9
      end
    end
  end

  assign burst_req   = offer_valid;
  assign burst_queue = offer_q;
  assign burst_len   = offer_valid ? len_arr[offer_q] : '0;
  assign burst_cause = offer_cause;

  AST_OFFER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_req && !burst_ack) |=> (burst_req && $stable(burst_queue)
      && $stable(burst_len) && $stable(burst_cause))); // R6
  AST_OFFER_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    burst_req |-> active_vec[burst_queue]); // R4
  AST_STALL_ONLY_ON_OFFER: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && !pkt_ready) |-> (burst_req && !burst_ack)); // R8
  AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (active_vec == '0) |-> !burst_req); // R4
endmodule

// File: tb/burst_assembler_bench.sv
`timescale 1ns/1ps
module burst_assembler_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pkt_valid = 1'b0;
  logic        pkt_ready;
  logic [1:0]  pkt_dest = '0;
  logic [0:0]  pkt_qos = '0;
  logic [15:0] pkt_len = '0;
  logic [19:0] cfg_len_thresh = '1;
  logic [15:0] cfg_timeout = '1;
  logic        burst_req;
  logic        burst_ack = 1'b0;
  logic [2:0]  burst_queue;
  logic [19:0] burst_len;
  logic        burst_cause;

  int checks = 0;
  int fails  = 0;
  int last_gnt = 7;

  always #4 clk = ~clk;

  burst_assembler u_burst_assembler (
    .clk(clk), .rst_n(rst_n),
    .pkt_valid(pkt_valid), .pkt_ready(pkt_ready),
    .pkt_dest(pkt_dest), .pkt_qos(pkt_qos), .pkt_len(pkt_len),
    .cfg_len_thresh(cfg_len_thresh), .cfg_timeout(cfg_timeout),
    .burst_req(burst_req), .burst_ack(burst_ack),
    .burst_queue(burst_queue), .burst_len(burst_len),
    .burst_cause(burst_cause)
  );

  task automatic expect_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // called just after a negedge; returns just after the negedge following the accept edge
  task automatic send(input int q, input int len);
    pkt_valid = 1'b1;
    pkt_dest  = 2'(q >> 1);
    pkt_qos   = 1'(q & 1);
    pkt_len   = 16'(len);
    #1 expect_eq("R8 ready for free queue", 32'(pkt_ready), 1);
    @(negedge clk);
    pkt_valid = 1'b0;
  endtask

  task automatic ack_now();
    last_gnt  = int'(burst_queue);
    burst_ack = 1'b1;
    @(negedge clk);
    burst_ack = 1'b0;
  endtask

  function automatic int next_rr(input int last, input logic [7:0] set);
    for (int k = 1; k <= 8; k++) begin
      if (set[(last + k) % 8]) return (last + k) % 8;
    end
    return -1;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    expect_eq("R6 reset req", 32'(burst_req), 0);
    expect_eq("R8 reset ready", 32'(pkt_ready), 1);
    expect_eq("R2 reset len", 32'(burst_len), 0);

    // R4 / R1: timeout sweep over every queue
    cfg_len_thresh = '1;
    for (int q = 0; q < 8; q++) begin
      int t;
      t = q + 2;
      cfg_timeout = 16'(t);
      send(q, (q + 1) * 37);
      expect_eq("R4 no req at accept", 32'(burst_req), 0);
      for (int k = 1; k <= t + 1; k++) begin
        @(negedge clk);
        expect_eq("R4 timeout timing", 32'(burst_req), (k == t + 1) ? 1 : 0);
      end
      expect_eq("R1 queue index", 32'(burst_queue), q);
      expect_eq("R2 burst length", 32'(burst_len), (q + 1) * 37);
      expect_eq("R4 cause timeout", 32'(burst_cause), 1);
      ack_now();
      expect_eq("R7 cleared after ack", 32'(burst_req), 0);
    end

    // R3: threshold sweep, equal is not enough
    cfg_timeout = '1;
    cfg_len_thresh = 20'd1000;
    for (int q = 0; q < 8; q++) begin
      send(q, 1000);
      @(negedge clk);
      expect_eq("R3 equal no req", 32'(burst_req), 0);
      send(q, q + 1);
      expect_eq("R3 not yet", 32'(burst_req), 0);
      @(negedge clk);
      expect_eq("R3 req after cross", 32'(burst_req), 1);
      expect_eq("R3 queue", 32'(burst_queue), q);
      expect_eq("R2 accumulated", 32'(burst_len), 1001 + q);
      expect_eq("R3 cause length", 32'(burst_cause), 0);
      ack_now();
    end

    // R5: both triggers together
    cfg_len_thresh = 20'd100;
    cfg_timeout = 16'd0;
    send(2, 200);
    @(negedge clk);
    expect_eq("R5 req", 32'(burst_req), 1);
    expect_eq("R5 cause length wins", 32'(burst_cause), 0);
    expect_eq("R5 len", 32'(burst_len), 200);
    ack_now();
    expect_eq("R5 single request", 32'(burst_req), 0);
    send(6, 5);
    @(negedge clk);
    expect_eq("R4 zero timeout cause", 32'(burst_cause), 1);
    ack_now();

    // R9: round robin over simultaneous requests, two rounds
    for (int round = 0; round < 2; round++) begin
      logic [7:0] set;
      set = (round == 0) ? 8'b0101_0010 : 8'b1001_0001;
      cfg_len_thresh = '1;
      cfg_timeout = '1;
      for (int q = 0; q < 8; q++) if (set[q]) send(q, 10 * (q + 1));
      cfg_len_thresh = 20'd0;
      @(negedge clk);
      for (int n = 0; n < 3; n++) begin
        int e;
        e = next_rr(last_gnt, set);
        expect_eq("R9 grant order", 32'(burst_queue), e);
        expect_eq("R9 req", 32'(burst_req), 1);
        expect_eq("R2 len", 32'(burst_len), 10 * (e + 1));
        @(negedge clk);
        expect_eq("R6 held queue", 32'(burst_queue), e);
        expect_eq("R6 held len", 32'(burst_len), 10 * (e + 1));
        set[e] = 1'b0;
        ack_now();
      end
      expect_eq("R9 all served", 32'(burst_req), 0);
    end

    // R8 / R7: stall to offered queue, packet in ack cycle starts next burst
    cfg_len_thresh = 20'd1000;
    cfg_timeout = '1;
    send(3, 1500);
    @(negedge clk);
    expect_eq("R3 req q3", 32'(burst_req), 1);
    pkt_valid = 1'b1; pkt_dest = 2'd1; pkt_qos = 1'b1; pkt_len = 16'd50;
    #1 expect_eq("R8 stall offered queue", 32'(pkt_ready), 0);
    pkt_qos = 1'b0;
    #1 expect_eq("R8 other queue flows", 32'(pkt_ready), 1);
    pkt_valid = 1'b0;
    @(negedge clk);
    expect_eq("R6 len held", 32'(burst_len), 1500);
    burst_ack = 1'b1;
    pkt_valid = 1'b1; pkt_dest = 2'd1; pkt_qos = 1'b1; pkt_len = 16'd50;
    #1 expect_eq("R8 ready in ack cycle", 32'(pkt_ready), 1);
    last_gnt = 3;
    @(negedge clk);
    burst_ack = 1'b0;
    pkt_valid = 1'b0;
    expect_eq("R7 no req below thresh", 32'(burst_req), 0);
    cfg_len_thresh = 20'd10;
    @(negedge clk);
    expect_eq("R7 next burst req", 32'(burst_req), 1);
    expect_eq("R7 next burst len", 32'(burst_len), 50);
    expect_eq("R7 next burst queue", 32'(burst_queue), 3);
    ack_now();

    // R10: saturation
    cfg_len_thresh = '1;
    cfg_timeout = '1;
    for (int n = 0; n < 17; n++) send(5, 65535);
    expect_eq("R10 no req", 32'(burst_req), 0);
    cfg_timeout = 16'd0;
    @(negedge clk);
    expect_eq("R10 req", 32'(burst_req), 1);
    expect_eq("R10 saturated len", 32'(burst_len), 20'hFFFFF);
    expect_eq("R10 cause", 32'(burst_cause), 1);
    ack_now();
    expect_eq("R10 cleared", 32'(burst_req), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule